// File: doc/BRIEF.md
# Guarded Mode Transition Controller

This block keeps track of whether a core runs in its ordinary mode or in a guarded mode. The guarded mode sits beside the ordinary mode at the same privilege level. It does not sit above it. The core's decoder presents one-cycle pulses for the guarded-enter and guarded-exit instructions, together with the current program counter. The block decides whether the transition is legal. For a legal transition it produces a program-counter redirect and updates the mode flag. For an illegal one it raises an undefined-instruction trap.

The guarded mode has its own bank of exception-state registers: return link, fault address, syndrome, saved status, vector base and thread pointer. The bank also holds two more registers. The first is an alternate-status register that decides where an exit lands. The second holds the entry address that an enter jumps to. Software reaches the bank through a simple system-register port: writes take effect at the clock edge, and each read answers one cycle after it is requested. The guarded mode shares the address translation tables with the ordinary mode and only sees them with different permissions, so nothing about translation lives here.

Top module: `gmode_ctrl`

## Requirements
- R1: After reset the mode flag is 0 (ordinary), redirect and trap are low, and every bank register reads as zero.
- R2: An enter pulse in ordinary mode, with bit 1 of the control word set and no exit pulse, sets the mode flag to 1 (guarded) one cycle later. In that same cycle it pulses the redirect with the entry-address register (selector 7) as target.
- R3: A legal enter stores the address of the next instruction, the PC plus 4 with wrap-around, into the return-link register (selector 0).
- R4: An enter pulse while bit 1 of the control word is clear, or while already guarded, raises the trap one cycle later. It does not redirect, does not change the mode, and leaves the return-link register untouched.
- R5: An exit pulse in guarded mode redirects to the return-link register one cycle later. Afterwards the mode flag equals bit 0 of the alternate-status register (selector 6): 1 stays guarded and 0 returns to ordinary.
- R6: An exit pulse in ordinary mode raises the trap one cycle later and leaves the mode ordinary, with no redirect.
- R7: Enter and exit pulses in the same cycle are undefined: trap, no redirect, mode unchanged.
- R8: Bank selectors are 0 return link, 1 fault address, 2 syndrome, 3 saved status, 4 vector base, 5 thread pointer, 6 alternate status, 7 entry address. A write changes only the selected register. A read returns data and a valid flag in the next cycle, with the contents as they stood before any write in the same cycle. The valid flag is low in cycles that follow no read.
- R9: A register write in the same cycle as a transition takes effect first. The transition uses the newly written entry address, return link or alternate status. A return-link write during a legal enter is then overwritten by the saved next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | XLEN | Control register contents; bit EN_BIT enables guarded mode |
| enter_i | input | 1 | Decoded guarded-enter instruction pulse |
| exit_i | input | 1 | Decoded guarded-exit instruction pulse |
| pc_i | input | XLEN | Address of the instruction carrying the pulse |
| sr_wr_en | input | 1 | Bank register write strobe |
| sr_rd_en | input | 1 | Bank register read strobe |
| sr_sel | input | 3 | Bank register selector |
| sr_wdata | input | XLEN | Write data |
| sr_rdata | output | XLEN | Read data, valid with sr_rvalid |
| sr_rvalid | output | 1 | Read response valid, one cycle after sr_rd_en |
| redir_valid | output | 1 | Program-counter redirect pulse |
| redir_pc | output | XLEN | Redirect target |
| guarded | output | 1 | Current mode: 1 guarded, 0 ordinary |
| undef_trap | output | 1 | Undefined-instruction trap pulse |

## Verification
The bench builds the block with XLEN set to 32, INSN_BYTES at 4 and EN_BIT at 1. The 32-bit width keeps each bank pattern short enough to write out as a literal. It also lets an enter at address 0xFFFF_FFFC show the wrap of the saved return link to zero. With EN_BIT left at 1, the bench can flip that one control bit while other bits of the control word stay set, and show that only bit 1 gates entry.

// File: rtl/gmode_pkg.sv
package gmode_pkg;
    localparam int unsigned NUM_BANK_REGS = 8;
    localparam int unsigned SEL_W         = $clog2(NUM_BANK_REGS);

    typedef enum logic [SEL_W-1:0] {
        SEL_LINK  = 3'd0,
        SEL_FAULT = 3'd1,
        SEL_SYND  = 3'd2,
        SEL_SSTAT = 3'd3,
        SEL_VECB  = 3'd4,
        SEL_THRD  = 3'd5,
        SEL_ALTST = 3'd6,
        SEL_ENTRY = 3'd7
    } gsel_e;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_GUARDED = 1'b1
    } gmode_e;
endpackage

// File: rtl/gmode_bank.sv
module gmode_bank
    import gmode_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             save_en,
    input  logic [XLEN-1:0]  save_data,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [XLEN-1:0]  rd_data,
    output logic             rd_valid,
    output logic [XLEN-1:0]  link_fwd,
    output logic [XLEN-1:0]  entry_fwd,
    output logic             alt_ret_fwd
);
    typedef struct packed {
        logic [NUM_BANK_REGS-1:0][XLEN-1:0] regs;
        logic [XLEN-1:0]                    rdata;
        logic                               rvalid;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_BANK_REGS-1:0][XLEN-1:0] wr_view;

    // Write-first view of every register, used by the transition logic.
    for (genvar gi = 0; gi < NUM_BANK_REGS; gi++) begin : g_view
        assign wr_view[gi] = (wr_en && wr_sel == SEL_W'(gi)) ? wr_data : st_q.regs[gi];
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.rdata = st_q.regs[rd_sel];
        end
        st_d.regs = wr_view;
        if (save_en) begin
            st_d.regs[SEL_LINK] = save_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.rdata;
    assign rd_valid    = st_q.rvalid;
    assign link_fwd    = wr_view[SEL_LINK];
    assign entry_fwd   = wr_view[SEL_ENTRY];
    assign alt_ret_fwd = wr_view[SEL_ALTST][0];
endmodule

// File: rtl/gmode_seq.sv
module gmode_seq
    import gmode_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned EN_BIT     = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] ctl_word,
    input  logic            enter_i,
    input  logic            exit_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] entry_fwd,
    input  logic [XLEN-1:0] link_fwd,
    input  logic            alt_ret_fwd,
    output logic            guarded_o,
    output logic            redir_valid_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            trap_o,
    output logic            save_en_o,
    output logic [XLEN-1:0] save_data_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        gmode_e          mode;
        logic            redir_v;
        logic [XLEN-1:0] redir_pc;
        logic            trap;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    en_bit, in_g, ok_enter, ok_exit;

    always_comb begin
        en_bit   = ctl_word[EN_BIT];
        in_g     = (st_q.mode == MODE_GUARDED);
        ok_enter = enter_i && !exit_i && en_bit && !in_g;
        ok_exit  = exit_i && !enter_i && in_g;

        st_d         = st_q;
        st_d.redir_v = 1'b0;
        st_d.trap    = 1'b0;
        save_en_o    = 1'b0;
        save_data_o  = pc_i + STEP;

        if (ok_enter) begin
            st_d.mode     = MODE_GUARDED;
            st_d.redir_v  = 1'b1;
            st_d.redir_pc = entry_fwd;
            save_en_o     = 1'b1;
        end else if (ok_exit) begin
            st_d.mode     = alt_ret_fwd ? MODE_GUARDED : MODE_NORMAL;
            st_d.redir_v  = 1'b1;
            st_d.redir_pc = link_fwd;
        end else if (enter_i || exit_i) begin
            st_d.trap = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORMAL, redir_v: 1'b0, redir_pc: '0, trap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign guarded_o     = (st_q.mode == MODE_GUARDED);
    assign redir_valid_o = st_q.redir_v;
    assign redir_pc_o    = st_q.redir_pc;
    assign trap_o        = st_q.trap;
endmodule

// File: rtl/gmode_ctrl.sv
module gmode_ctrl
    import gmode_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned EN_BIT     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  ctl_word,
    input  logic             enter_i,
    input  logic             exit_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             sr_wr_en,
    input  logic             sr_rd_en,
    input  logic [SEL_W-1:0] sr_sel,
    input  logic [XLEN-1:0]  sr_wdata,
    output logic [XLEN-1:0]  sr_rdata,
    output logic             sr_rvalid,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_pc,
    output logic             guarded,
    output logic             undef_trap
);
    logic            save_en;
    logic [XLEN-1:0] save_data;
    logic [XLEN-1:0] link_fwd;
    logic [XLEN-1:0] entry_fwd;
    logic            alt_ret_fwd;

    gmode_bank #(.XLEN(XLEN)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (sr_wr_en),
        .wr_sel      (sr_sel),
        .wr_data     (sr_wdata),
        .save_en     (save_en),
        .save_data   (save_data),
        .rd_en       (sr_rd_en),
        .rd_sel      (sr_sel),
        .rd_data     (sr_rdata),
        .rd_valid    (sr_rvalid),
        .link_fwd    (link_fwd),
        .entry_fwd   (entry_fwd),
        .alt_ret_fwd (alt_ret_fwd)
    );

    gmode_seq #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .EN_BIT(EN_BIT)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_word      (ctl_word),
        .enter_i       (enter_i),
        .exit_i        (exit_i),
        .pc_i          (pc_i),
        .entry_fwd     (entry_fwd),
        .link_fwd      (link_fwd),
        .alt_ret_fwd   (alt_ret_fwd),
        .guarded_o     (guarded),
        .redir_valid_o (redir_valid),
        .redir_pc_o    (redir_pc),
        .trap_o        (undef_trap),
        .save_en_o     (save_en),
        .save_data_o   (save_data)
    );
endmodule

// File: rtl/gmode_ctrl_chk.sv
module gmode_ctrl_chk #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned EN_BIT = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] ctl_word,
    input logic            enter_i,
    input logic            exit_i,
    input logic            sr_rd_en,
    input logic            sr_rvalid,
    input logic            redir_valid,
    input logic            guarded,
    input logic            undef_trap
);
    AST_ENTER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !exit_i && ctl_word[EN_BIT] && !guarded) |=> (guarded && redir_valid && !undef_trap)); // R2
    AST_ENTER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !exit_i && (!ctl_word[EN_BIT] || guarded)) |=> (undef_trap && !redir_valid)); // R4
    AST_TRAP_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_trap |-> $stable(guarded)); // R4
    AST_EXIT_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !enter_i && !guarded) |=> (undef_trap && !guarded && !redir_valid)); // R6
    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && exit_i) |=> (undef_trap && !redir_valid && $stable(guarded))); // R7
    AST_EXIT_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !enter_i && guarded) |=> (redir_valid && !undef_trap)); // R5
    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_rd_en |=> sr_rvalid); // R8
    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_rd_en |=> !sr_rvalid); // R8
endmodule

bind gmode_ctrl gmode_ctrl_chk #(.XLEN(XLEN), .EN_BIT(EN_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_word    (ctl_word),
    .enter_i     (enter_i),
    .exit_i      (exit_i),
    .sr_rd_en    (sr_rd_en),
    .sr_rvalid   (sr_rvalid),
    .redir_valid (redir_valid),
    .guarded     (guarded),
    .undef_trap  (undef_trap)
);

// File: tb/gmode_ctrl_bench.sv
module gmode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int WATCHDOG   = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] ctl_word = '0;
    logic            enter_i = 1'b0, exit_i = 1'b0;
    logic [XLEN-1:0] pc_i = '0;
    logic            sr_wr_en = 1'b0, sr_rd_en = 1'b0;
    logic [2:0]      sr_sel = '0;
    logic [XLEN-1:0] sr_wdata = '0;
    logic [XLEN-1:0] sr_rdata, redir_pc;
    logic            sr_rvalid, redir_valid, guarded, undef_trap;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gmode_ctrl #(.XLEN(XLEN), .INSN_BYTES(4), .EN_BIT(1)) u_gmode_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .enter_i(enter_i), .exit_i(exit_i),
        .pc_i(pc_i), .sr_wr_en(sr_wr_en), .sr_rd_en(sr_rd_en), .sr_sel(sr_sel),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .sr_rvalid(sr_rvalid),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .guarded(guarded), .undef_trap(undef_trap)
    );

    // {selector, data}: one distinct pattern per bank register
    localparam logic [34:0] WR_VEC [8] = '{
        {3'd0, 32'hA5A5_0001}, {3'd1, 32'h1111_2222}, {3'd2, 32'hFFFF_FFFF},
        {3'd3, 32'h8000_0000}, {3'd4, 32'h0000_0800}, {3'd5, 32'hDEAD_BEEF},
        {3'd6, 32'hFFFF_FFFE}, {3'd7, 32'h0000_4000}
    };

    task automatic chk(input string req, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sw(input logic [2:0] sel, input logic [XLEN-1:0] data);
        sr_wr_en = 1'b1; sr_sel = sel; sr_wdata = data;
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    task automatic sr(input logic [2:0] sel, output logic [XLEN-1:0] data);
        sr_rd_en = 1'b1; sr_sel = sel;
        @(negedge clk);
        sr_rd_en = 1'b0;
        data = sr_rdata;
        chk("R8", "read valid", XLEN'(sr_rvalid), 1);
    endtask

    task automatic strobe(input logic en, input logic ex, input logic [XLEN-1:0] pc);
        enter_i = en; exit_i = ex; pc_i = pc;
        @(negedge clk);
        enter_i = 1'b0; exit_i = 1'b0; sr_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        logic [XLEN-1:0] rv;
        do_reset();
        // R1: reset state
        chk("R1", "mode after reset", XLEN'(guarded), 0);
        chk("R1", "redirect after reset", XLEN'(redir_valid), 0);
        chk("R1", "trap after reset", XLEN'(undef_trap), 0);
        for (int k = 0; k < 8; k++) begin
            sr(3'(k), rv);
            chk("R1", "bank zero after reset", rv, 0);
        end
        @(negedge clk);
        chk("R8", "valid low when idle", XLEN'(sr_rvalid), 0);

        // R8: write every register, read each back
        for (int k = 0; k < 8; k++) sw(WR_VEC[k][34:32], WR_VEC[k][31:0]);
        for (int k = 0; k < 8; k++) begin
            sr(WR_VEC[k][34:32], rv);
            chk("R8", "bank readback", rv, WR_VEC[k][31:0]);
        end

        // R4: enter with enable bit clear (other bits set)
        ctl_word = 32'hFFFF_FFFD;
        strobe(1'b1, 1'b0, 32'h100);
        chk("R4", "trap on disabled enter", XLEN'(undef_trap), 1);
        chk("R4", "no redirect on disabled enter", XLEN'(redir_valid), 0);
        chk("R4", "mode stays ordinary", XLEN'(guarded), 0);
        sr(3'd0, rv);
        chk("R4", "link untouched", rv, 32'hA5A5_0001);

        // R6: exit in ordinary mode
        ctl_word = 32'h0000_0002;
        strobe(1'b0, 1'b1, 32'h120);
        chk("R6", "trap on exit in ordinary", XLEN'(undef_trap), 1);
        chk("R6", "mode stays ordinary", XLEN'(guarded), 0);
        chk("R6", "no redirect", XLEN'(redir_valid), 0);

        // R2, R3: legal enter
        strobe(1'b1, 1'b0, 32'h200);
        chk("R2", "mode guarded", XLEN'(guarded), 1);
        chk("R2", "redirect pulse", XLEN'(redir_valid), 1);
        chk("R2", "redirect target", redir_pc, 32'h0000_4000);
        chk("R2", "no trap", XLEN'(undef_trap), 0);
        @(negedge clk);
        chk("R2", "redirect is a pulse", XLEN'(redir_valid), 0);
        sr(3'd0, rv);
        chk("R3", "link holds next pc", rv, 32'h204);

        // R4: enter while guarded
        strobe(1'b1, 1'b0, 32'h300);
        chk("R4", "trap on nested enter", XLEN'(undef_trap), 1);
        chk("R4", "mode stays guarded", XLEN'(guarded), 1);
        sr(3'd0, rv);
        chk("R4", "link untouched by nested enter", rv, 32'h204);

        // R7: both strobes
        strobe(1'b1, 1'b1, 32'h310);
        chk("R7", "trap on both", XLEN'(undef_trap), 1);
        chk("R7", "no redirect on both", XLEN'(redir_valid), 0);
        chk("R7", "mode unchanged", XLEN'(guarded), 1);

        // R5: exit with alternate bit 0 set stays guarded
        sw(3'd6, 32'h0000_0001);
        strobe(1'b0, 1'b1, 32'h320);
        chk("R5", "redirect to link", redir_pc, 32'h204);
        chk("R5", "redirect pulse", XLEN'(redir_valid), 1);
        chk("R5", "stays guarded", XLEN'(guarded), 1);

        // R9 + R5: clear alternate bit in the same cycle as exit
        sr_wr_en = 1'b1; sr_sel = 3'd6; sr_wdata = 32'hFFFF_FFFE;
        strobe(1'b0, 1'b1, 32'h330);
        chk("R9", "exit uses fresh alternate bit", XLEN'(guarded), 0);
        chk("R5", "redirect to link", redir_pc, 32'h204);

        // R9: entry written with the enter; R3 wrap
        sr_wr_en = 1'b1; sr_sel = 3'd7; sr_wdata = 32'h0000_8000;
        strobe(1'b1, 1'b0, 32'hFFFF_FFFC);
        chk("R9", "enter uses fresh entry", redir_pc, 32'h0000_8000);
        sr(3'd0, rv);
        chk("R3", "link wraps to zero", rv, 32'h0);

        // R9: link written with the enter is overwritten by saved address
        strobe(1'b0, 1'b1, 32'h0);
        sr_wr_en = 1'b1; sr_sel = 3'd0; sr_wdata = 32'h7777_7777;
        strobe(1'b1, 1'b0, 32'h500);
        sr(3'd0, rv);
        chk("R9", "saved address wins over link write", rv, 32'h504);

        // R9: link written with the exit
        sr_wr_en = 1'b1; sr_sel = 3'd0; sr_wdata = 32'h0000_1234;
        strobe(1'b0, 1'b1, 32'h600);
        chk("R9", "exit uses fresh link", redir_pc, 32'h0000_1234);

        // R8: read and write same register together returns old value
        sr_wr_en = 1'b1; sr_wdata = 32'h5555_AAAA;
        sr(3'd5, rv);
        sr_wr_en = 1'b0;
        chk("R8", "read sees old contents", rv, 32'hDEAD_BEEF);
        sr(3'd5, rv);
        chk("R8", "write landed", rv, 32'h5555_AAAA);
        sr(3'd1, rv);
        chk("R8", "neighbour untouched", rv, 32'h1111_2222);

        // R1: reset while guarded
        strobe(1'b1, 1'b0, 32'h700);
        chk("R2", "guarded before reset", XLEN'(guarded), 1);
        do_reset();
        chk("R1", "reset leaves guarded mode", XLEN'(guarded), 0);
        sr(3'd7, rv);
        chk("R1", "entry cleared by reset", rv, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule